// File: doc/BRIEF.md
# DMA Beat Width and Alignment Planner

This block sits between a DMA engine and a 64-bit bus master. The engine hands it one request at a time: a start address, a byte count, an end-of-message flag and the kind of transfer. The block turns that request into a series of bus beats. Each beat carries an address, a width (one 64-bit word or one 32-bit half) and eight byte enables. Three plain configuration pins shape the plan. One says whether the far side reliably takes 64-bit beats. One turns on the mode for error-corrected shared memory. One picks the byte order of the storage.

Requests arrive on a valid/ready handshake. `req_ready` is high only while no plan is in progress, so a request is held off until the final beat of the current plan has been taken. Beats leave on a second valid/ready handshake. A beat offered with `beat_valid` stays on the pins unchanged until `beat_ready` takes it, and the consumer may stall for any number of cycles. The configuration pins are sampled when a request is accepted. During ECC mode, a receive transfer without end-of-message is cut back to a word boundary. The cut-off byte count and the untouched request pointer are then held on plain outputs until the next request is accepted.

Top module: `dma_width_planner`

## Requirements
- R1: After reset `req_ready` is 1 and `beat_valid` is 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. The first beat is valid in the next cycle. `req_ready` stays 0 until the edge where the final beat is taken, and is 1 again in the following cycle.
- R2: While `beat_valid` is 1 and `beat_ready` is 0, the beat's address, width, byte enables and last flag do not change. A change of configuration pins during a plan does not alter it.
- R3: A plan whose bytes all fall in one 64-bit word is sent as 32-bit beats (`beat_wide`=0) when `cfg_wide_ok` is 0. There is one beat for each 32-bit half that holds a byte. The lower half goes first at the word address and the upper half follows at word address + 4.
- R4: A plan spanning two or more 64-bit words always uses 64-bit beats (`beat_wide`=1) on 8-aligned addresses, whatever the value of `cfg_wide_ok`. A one-word plan with `cfg_wide_ok`=1 is one 64-bit beat.
- R5: Outside ECC mode the first and last beats enable only the bytes from the start offset and up to the last byte. With `cfg_big_endian`=0, the byte at offset k of an 8-byte word is enabled on lane k (bit k of `beat_be`). Every beat enables at least one byte.
- R6: With `cfg_big_endian`=1, the byte at offset k is enabled on lane 7-k.
- R7: In ECC mode (`cfg_ecc`=1), the low three address bits of transmit and receive data requests are taken as zero for beat addressing. `plan_ptr` holds the request address exactly as given, low bits included.
- R8: `req_kind`=2 is a descriptor writeback. In ECC mode it writes the whole 8-byte descriptor at the 8-aligned request address, following R3/R4. Outside ECC mode it writes only the 4-byte status dword at aligned address + 4, as a single 32-bit beat.
- R9: An ECC-mode receive request (`req_kind`=1) with `req_eom`=0 is cut to its last 8-byte boundary, and `plan_trim` reports the dropped byte count (count mod 8). If nothing is left, the request is taken and no beat is sent.
- R10: A data request with zero count is taken, sends no beat, and leaves `plan_trim` at 0.
- R11: `beat_last` is 1 on the final beat of a plan and only there. No beat is valid in the cycle after the final beat is taken.
- R12: No cut is made outside ECC mode, for transmit requests (`req_kind` 0 or 3), or when `req_eom` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide_ok | input | 1 | Far side always takes 64-bit beats |
| cfg_ecc | input | 1 | ECC shared-memory mode |
| cfg_big_endian | input | 1 | 1 = big-endian storage, 0 = little-endian |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle if offered |
| req_addr | input | 32 | Start address (data pointer or descriptor address) |
| req_count | input | 16 | Byte count for data requests |
| req_eom | input | 1 | Request holds the end of message |
| req_kind | input | 2 | 0 transmit, 1 receive, 2 descriptor writeback, 3 as transmit |
| beat_valid | output | 1 | Beat offered |
| beat_ready | input | 1 | Beat taken this cycle if offered |
| beat_addr | output | 32 | Beat address |
| beat_wide | output | 1 | 1 = 64-bit beat, 0 = 32-bit beat |
| beat_be | output | 8 | Byte enables by lane |
| beat_last | output | 1 | Final beat of the plan |
| plan_trim | output | 16 | Bytes dropped from the last accepted request |
| plan_ptr | output | 32 | Untouched address of the last accepted request |

## Verification
Some properties are checked on every cycle. A stalled beat must hold still. No beat may follow the final one in the next cycle. Wide beats must sit on word boundaries. A narrow beat may enable lanes in only one half, and every beat must enable some byte. The reported cut must stay below one word. The bench scenarios cover the rest: whether the split between narrow and wide beats is chosen correctly, the exact enables on partial words in each byte order, and the ECC pointer masking and trimming. They also show the descriptor writeback forms, the zero-beat plans, and the holding off of a second request until the plan ends.

// File: rtl/dma_plan_pkg.sv
package dma_plan_pkg;
  typedef enum logic [1:0] {
    XFER_TX    = 2'd0,
    XFER_RX    = 2'd1,
    XFER_DESC  = 2'd2,
    XFER_SPARE = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/dma_plan_setup.sv
// Combinational planning of one request: effective base, length, word span,
// offsets of the first and last byte, split decision and trimmed remainder.
module dma_plan_setup
  import dma_plan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LANES  = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int HALF   = LANES / 2,
  localparam int WCNT_W = CNT_W + 2
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_eom,
  input  xfer_kind_e        req_kind,
  input  logic              cfg_wide_ok,
  input  logic              cfg_ecc,
  output logic [ADDR_W-1:0] plan_word_addr,
  output logic [OFF_W-1:0]  plan_first_off,
  output logic [OFF_W-1:0]  plan_last_off,
  output logic [WCNT_W-1:0] plan_words,
  output logic              plan_split,
  output logic              plan_lo_need,
  output logic              plan_hi_need,
  output logic              plan_empty,
  output logic [CNT_W-1:0]  plan_trim
);
  logic              is_desc;
  logic              is_rx;
  logic              cut_on;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  len;
  logic [CNT_W-1:0]  low_mask;
  logic [WCNT_W-1:0] span;

  always_comb begin
    is_desc  = (req_kind == XFER_DESC);
    is_rx    = (req_kind == XFER_RX);
    aligned  = req_addr & ~ADDR_W'(LANES - 1);
    low_mask = CNT_W'(LANES - 1);
    cut_on   = cfg_ecc && is_rx && !req_eom;
    if (is_desc) begin
      base = cfg_ecc ? aligned : aligned + ADDR_W'(HALF);
      len  = cfg_ecc ? CNT_W'(LANES) : CNT_W'(HALF);
    end else begin
      base = cfg_ecc ? aligned : req_addr;
      len  = cut_on ? (req_count & ~low_mask) : req_count;
    end
    plan_trim      = cut_on ? (req_count & low_mask) : '0;
    span           = WCNT_W'(base[OFF_W-1:0]) + WCNT_W'(len);
    plan_words     = (span + WCNT_W'(LANES - 1)) >> OFF_W;
    plan_first_off = base[OFF_W-1:0];
    plan_last_off  = base[OFF_W-1:0] + len[OFF_W-1:0] - OFF_W'(1);
    plan_word_addr = base & ~ADDR_W'(LANES - 1);
    plan_empty     = (len == '0);
    plan_split     = (plan_words == WCNT_W'(1)) &&
                     (!cfg_wide_ok || (is_desc && !cfg_ecc));
    plan_lo_need   = (plan_first_off < OFF_W'(HALF));
    plan_hi_need   = (plan_last_off >= OFF_W'(HALF));
  end
endmodule

// File: rtl/dma_beat_seq.sv
// Walks a latched plan beat by beat under valid/ready back-pressure.
module dma_beat_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LANES  = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int HALF   = LANES / 2,
  localparam int WCNT_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] plan_word_addr,
  input  logic [OFF_W-1:0]  plan_first_off,
  input  logic [OFF_W-1:0]  plan_last_off,
  input  logic [WCNT_W-1:0] plan_words,
  input  logic              plan_split,
  input  logic              plan_lo_need,
  input  logic              plan_hi_need,
  input  logic              plan_empty,
  input  logic              beat_ready,
  output logic              busy,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_wide,
  output logic [LANES-1:0]  beat_mask,
  output logic              beat_last
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WCNT_W-1:0] left_q;
  logic [OFF_W-1:0]  foff_q;
  logic [OFF_W-1:0]  loff_q;
  logic              first_q;
  logic              split_q;
  logic              half_q;
  logic              hi_need_q;
  logic              fire;
  logic              last_word;
  logic [OFF_W-1:0]  lo_off;
  logic [OFF_W-1:0]  hi_off;

  assign busy       = busy_q;
  assign beat_valid = busy_q;
  assign fire       = busy_q && beat_ready;
  assign last_word  = (left_q == WCNT_W'(1));

  always_comb begin
    lo_off    = first_q ? foff_q : '0;
    hi_off    = last_word ? loff_q : OFF_W'(LANES - 1);
    beat_wide = !split_q;
    beat_addr = addr_q + ((split_q && half_q) ? ADDR_W'(HALF) : '0);
    beat_last = split_q ? (half_q || !hi_need_q) : last_word;
    for (int k = 0; k < LANES; k++) begin
      beat_mask[k] = (OFF_W'(k) >= lo_off) && (OFF_W'(k) <= hi_off);
      if (split_q && ((k >= HALF) != half_q)) beat_mask[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      addr_q    <= '0;
      left_q    <= '0;
      foff_q    <= '0;
      loff_q    <= '0;
      first_q   <= 1'b0;
      split_q   <= 1'b0;
      half_q    <= 1'b0;
      hi_need_q <= 1'b0;
    end else if (load) begin
      busy_q    <= !plan_empty;
      addr_q    <= plan_word_addr;
      left_q    <= plan_words;
      foff_q    <= plan_first_off;
      loff_q    <= plan_last_off;
      first_q   <= 1'b1;
      split_q   <= plan_split;
      half_q    <= plan_split && !plan_lo_need;
      hi_need_q <= plan_hi_need;
    end else if (fire) begin
      if (beat_last) begin
        busy_q <= 1'b0;
      end else if (split_q) begin
        half_q <= 1'b1;
      end else begin
        addr_q  <= addr_q + ADDR_W'(LANES);
        left_q  <= left_q - WCNT_W'(1);
        first_q <= 1'b0;
      end
    end
  end

  // R2: a stalled beat holds every field
  assert_beat_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) &&
    $stable(beat_mask) && $stable(beat_wide) && $stable(beat_last));

  // R11: nothing follows the final beat in the next cycle
  assert_last_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_ready && beat_last |=> !beat_valid);

  // R4: wide beats sit on word boundaries
  assert_wide_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && beat_wide |-> beat_addr[OFF_W-1:0] == '0);
endmodule

// File: rtl/dma_lane_map.sv
// Maps byte-offset enables onto bus lanes for the selected byte order.
module dma_lane_map #(
  parameter int LANES = 8
) (
  input  logic             big_endian,
  input  logic [LANES-1:0] offset_mask,
  output logic [LANES-1:0] lane_be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_be[g] = big_endian ? offset_mask[LANES-1-g] : offset_mask[g];
  end
endmodule

// File: rtl/dma_width_planner.sv
module dma_width_planner
  import dma_plan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int LANES  = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int HALF   = LANES / 2,
  localparam int WCNT_W = CNT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide_ok,
  input  logic              cfg_ecc,
  input  logic              cfg_big_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              req_eom,
  input  logic [1:0]        req_kind,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_wide,
  output logic [LANES-1:0]  beat_be,
  output logic              beat_last,
  output logic [CNT_W-1:0]  plan_trim,
  output logic [ADDR_W-1:0] plan_ptr
);
  logic              busy;
  logic              accept;
  logic              order_q;
  logic [CNT_W-1:0]  trim_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] s_word_addr;
  logic [OFF_W-1:0]  s_first_off;
  logic [OFF_W-1:0]  s_last_off;
  logic [WCNT_W-1:0] s_words;
  logic              s_split;
  logic              s_lo_need;
  logic              s_hi_need;
  logic              s_empty;
  logic [CNT_W-1:0]  s_trim;
  logic [LANES-1:0]  offset_mask;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign plan_trim = trim_q;
  assign plan_ptr  = ptr_q;

  dma_plan_setup #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) u_setup (
    .req_addr       (req_addr),
    .req_count      (req_count),
    .req_eom        (req_eom),
    .req_kind       (xfer_kind_e'(req_kind)),
    .cfg_wide_ok    (cfg_wide_ok),
    .cfg_ecc        (cfg_ecc),
    .plan_word_addr (s_word_addr),
    .plan_first_off (s_first_off),
    .plan_last_off  (s_last_off),
    .plan_words     (s_words),
    .plan_split     (s_split),
    .plan_lo_need   (s_lo_need),
    .plan_hi_need   (s_hi_need),
    .plan_empty     (s_empty),
    .plan_trim      (s_trim)
  );

  dma_beat_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (accept),
    .plan_word_addr (s_word_addr),
    .plan_first_off (s_first_off),
    .plan_last_off  (s_last_off),
    .plan_words     (s_words),
    .plan_split     (s_split),
    .plan_lo_need   (s_lo_need),
    .plan_hi_need   (s_hi_need),
    .plan_empty     (s_empty),
    .beat_ready     (beat_ready),
    .busy           (busy),
    .beat_valid     (beat_valid),
    .beat_addr      (beat_addr),
    .beat_wide      (beat_wide),
    .beat_mask      (offset_mask),
    .beat_last      (beat_last)
  );

  dma_lane_map #(.LANES(LANES)) u_lanes (
    .big_endian  (order_q),
    .offset_mask (offset_mask),
    .lane_be     (beat_be)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 1'b0;
      trim_q  <= '0;
      ptr_q   <= '0;
    end else if (accept) begin
      order_q <= cfg_big_endian;
      trim_q  <= s_trim;
      ptr_q   <= req_addr;
    end
  end

  // R3: a narrow beat touches lanes of one half only
  assert_narrow_one_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_wide |-> (beat_be[LANES-1:HALF] == '0) || (beat_be[HALF-1:0] == '0));

  // R5: every offered beat enables some byte
  assert_be_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_be != '0);

  // R9: the cut never reaches a full word
  assert_trim_small_R9: assert property (@(posedge clk) disable iff (!rst_n)
    plan_trim < CNT_W'(LANES));

  // R1: no new request while a beat is pending
  assert_one_plan_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);
endmodule

// File: tb/dma_width_planner_test.sv
module dma_width_planner_test;
  typedef struct packed {
    logic [31:0] addr;
    logic [15:0] cnt;
    logic        eom;
    logic [1:0]  kind;
    logic        t64;
    logic        ecc;
    logic        big;
    logic [7:0]  nb;
    logic [31:0] fa;
    logic        fw;
    logic [7:0]  fbe;
    logic [31:0] la;
    logic        lw;
    logic [7:0]  lbe;
    logic [15:0] trim;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R3 full word, narrow target: two halves
    '{32'h100, 16'd8,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'd2, 32'h100, 1'b0, 8'h0F, 32'h104, 1'b0, 8'hF0, 16'd0},
    // R4 full word, wide target: one beat
    '{32'h100, 16'd8,  1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 8'd1, 32'h100, 1'b1, 8'hFF, 32'h100, 1'b1, 8'hFF, 16'd0},
    // R3 bytes only in lower half
    '{32'h102, 16'd2,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'd1, 32'h100, 1'b0, 8'h0C, 32'h100, 1'b0, 8'h0C, 16'd0},
    // R3 bytes only in upper half
    '{32'h105, 16'd3,  1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 8'd1, 32'h104, 1'b0, 8'hE0, 32'h104, 1'b0, 8'hE0, 16'd0},
    // R4 R5 three words, partial ends
    '{32'h103, 16'd20, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'd3, 32'h100, 1'b1, 8'hF8, 32'h110, 1'b1, 8'h7F, 16'd0},
    // R6 same, big-endian lanes
    '{32'h103, 16'd20, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 8'd3, 32'h100, 1'b1, 8'h1F, 32'h110, 1'b1, 8'hFE, 16'd0},
    // R6 narrow, big-endian
    '{32'h102, 16'd2,  1'b1, 2'd0, 1'b0, 1'b0, 1'b1, 8'd1, 32'h100, 1'b0, 8'h30, 32'h100, 1'b0, 8'h30, 16'd0},
    // R7 ECC masks pointer low bits
    '{32'h205, 16'd16, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 8'd2, 32'h200, 1'b1, 8'hFF, 32'h208, 1'b1, 8'hFF, 16'd0},
    // R9 ECC receive cut to one word
    '{32'h300, 16'd13, 1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 8'd1, 32'h300, 1'b1, 8'hFF, 32'h300, 1'b1, 8'hFF, 16'd5},
    // R9 R7 ECC receive, unaligned pointer, cut to two words
    '{32'h303, 16'd20, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 8'd2, 32'h300, 1'b1, 8'hFF, 32'h308, 1'b1, 8'hFF, 16'd4},
    // R12 no cut outside ECC
    '{32'h300, 16'd13, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 8'd2, 32'h300, 1'b1, 8'hFF, 32'h308, 1'b1, 8'h1F, 16'd0},
    // R12 no cut with end-of-message
    '{32'h300, 16'd13, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 8'd2, 32'h300, 1'b1, 8'hFF, 32'h308, 1'b1, 8'h1F, 16'd0},
    // R8 ECC descriptor, wide target
    '{32'h400, 16'd0,  1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 8'd1, 32'h400, 1'b1, 8'hFF, 32'h400, 1'b1, 8'hFF, 16'd0},
    // R8 ECC descriptor, narrow target
    '{32'h400, 16'd0,  1'b0, 2'd2, 1'b0, 1'b1, 1'b0, 8'd2, 32'h400, 1'b0, 8'h0F, 32'h404, 1'b0, 8'hF0, 16'd0},
    // R8 status dword only
    '{32'h400, 16'd0,  1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 8'd1, 32'h404, 1'b0, 8'hF0, 32'h404, 1'b0, 8'hF0, 16'd0},
    // R8 R6 status dword, big-endian
    '{32'h400, 16'd0,  1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 8'd1, 32'h404, 1'b0, 8'h0F, 32'h404, 1'b0, 8'h0F, 16'd0},
    // R10 zero count
    '{32'h500, 16'd0,  1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0,   1'b0, 8'h00, 32'h0,   1'b0, 8'h00, 16'd0},
    // R9 cut to nothing
    '{32'h300, 16'd5,  1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 8'd0, 32'h0,   1'b0, 8'h00, 32'h0,   1'b0, 8'h00, 16'd5},
    // R12 ECC transmit without end-of-message keeps length
    '{32'h300, 16'd13, 1'b0, 2'd3, 1'b1, 1'b1, 1'b0, 8'd2, 32'h300, 1'b1, 8'hFF, 32'h308, 1'b1, 8'h1F, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wide_ok = 1'b0;
  logic        cfg_ecc = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [15:0] req_count = '0;
  logic        req_eom = 1'b0;
  logic [1:0]  req_kind = '0;
  logic        beat_valid;
  logic        beat_ready = 1'b0;
  logic [31:0] beat_addr;
  logic        beat_wide;
  logic [7:0]  beat_be;
  logic        beat_last;
  logic [15:0] plan_trim;
  logic [31:0] plan_ptr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dma_width_planner uut (
    .clk(clk), .rst_n(rst_n), .cfg_wide_ok(cfg_wide_ok), .cfg_ecc(cfg_ecc),
    .cfg_big_endian(cfg_big_endian), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .req_eom(req_eom), .req_kind(req_kind),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_wide(beat_wide), .beat_be(beat_be), .beat_last(beat_last),
    .plan_trim(plan_trim), .plan_ptr(plan_ptr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int nb;
    logic [31:0] fa, la;
    logic fw, lw;
    logic [7:0] fbe, lbe;
    logic done;
    nb = 0; fa = '0; la = '0; fw = 0; lw = 0; fbe = '0; lbe = '0; done = 0;
    chk($sformatf("vec%0d R1 ready before request", idx), 64'(req_ready), 64'd1);
    cfg_wide_ok = v.t64; cfg_ecc = v.ecc; cfg_big_endian = v.big;
    req_addr = v.addr; req_count = v.cnt; req_eom = v.eom; req_kind = v.kind;
    req_valid = 1'b1; beat_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 40 && !done; c++) begin
      if (beat_valid) begin
        if (nb == 0) begin fa = beat_addr; fw = beat_wide; fbe = beat_be; end
        la = beat_addr; lw = beat_wide; lbe = beat_be;
        nb++;
        if (beat_last) done = 1;
      end
      @(negedge clk);
    end
    chk($sformatf("vec%0d R11 beat count", idx), 64'(nb), 64'(v.nb));
    if (v.nb != 0) begin
      chk($sformatf("vec%0d first addr", idx), 64'(fa), 64'(v.fa));
      chk($sformatf("vec%0d first width", idx), 64'(fw), 64'(v.fw));
      chk($sformatf("vec%0d first enables", idx), 64'(fbe), 64'(v.fbe));
      chk($sformatf("vec%0d last addr", idx), 64'(la), 64'(v.la));
      chk($sformatf("vec%0d last width", idx), 64'(lw), 64'(v.lw));
      chk($sformatf("vec%0d last enables", idx), 64'(lbe), 64'(v.lbe));
    end
    chk($sformatf("vec%0d R9 trim", idx), 64'(plan_trim), 64'(v.trim));
    chk($sformatf("vec%0d R7 pointer echo", idx), 64'(plan_ptr), 64'(v.addr));
  endtask

  initial begin
    #(20 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 ready in reset", 64'(req_ready), 64'd1);
    chk("R1 no beat in reset", 64'(beat_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 64'(req_ready), 64'd1);
    chk("R1 no beat after reset", 64'(beat_valid), 64'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R1 R2: three-word plan under back-pressure, with a second request waiting
    cfg_wide_ok = 1'b0; cfg_ecc = 1'b0; cfg_big_endian = 1'b0;
    req_addr = 32'h103; req_count = 16'd20; req_eom = 1'b1; req_kind = 2'd0;
    req_valid = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    chk("R1 first beat one cycle after accept", 64'(beat_valid), 64'd1);
    chk("R1 request held off", 64'(req_ready), 64'd0);
    req_addr = 32'h700; req_count = 16'd8;
    cfg_big_endian = 1'b1;
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      chk("R2 stalled addr", 64'(beat_addr), 64'h100);
      chk("R2 stalled enables, order change ignored", 64'(beat_be), 64'hF8);
      chk("R1 request still held off", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    beat_ready = 1'b1;
    @(negedge clk);
    chk("R4 middle beat", 64'(beat_addr), 64'h108);
    chk("R5 middle enables", 64'(beat_be), 64'hFF);
    chk("R1 ready low before last", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R11 last flag", 64'(beat_last), 64'd1);
    chk("R5 last enables little-endian", 64'(beat_be), 64'h7F);
    @(negedge clk);
    chk("R11 idle after last", 64'(beat_valid), 64'd0);
    chk("R1 ready after last", 64'(req_ready), 64'd1);
    chk("R7 held request not taken", 64'(plan_ptr), 64'h103);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule